// File: doc/BRIEF.md
# Memory Error Capture and Exception Register

This block gathers fault events seen around a memory controller. One source is the DRAM ECC checker, which can report correctable or uncorrectable errors separately for the upper and the lower 64-bit half of a 128-bit access. The other sources are the two processor interfaces, which report address-translation, handshake, status, data and addressing faults. Each event sets a sticky bit in an exception status register. The block raises a single interrupt when any status bit is set whose mask bit is enabled.

For the first ECC fault after the ECC status bits have been cleared, the block keeps the DRAM coordinates of the failing access: burst count, rank, column, bank and row. It also keeps both halves of the ECC syndrome. Later faults set further status bits but leave the captured record in place, so software always sees the earliest failure. Software reads the status register to learn the cause. That read also clears the register, which re-arms the capture. A check-control register switches ECC event collection on or off as a whole.

All registers are 32 bits wide and numbered with bit 0 as the most significant bit, so bit n sits at word position 31-n. Event strobe index n on the `evt_strobe` port maps to register bit n.

Top module: `memerr_unit`

## Requirements
- R1: After a synchronous active-low reset the registers read as follows. The mask register (word address 0) reads 0xFEF00000, with every defined bit enabled. The status register (address 1), the error-address register (address 2) and the syndrome register (address 3) read 0. The check-control register (address 4) reads 0x80000000, which means ECC collection is enabled. `irq` is low.
- R2: An event strobe `evt_strobe[n]` sets status bit n, at word position 31-n, on the next clock edge. The bit stays set until the status register is read. The event numbers are 0 for address translation, 1 and 2 for a handshake fault on interface 0 and 1, 3 for a status fault, 4 for a data error, and 5 and 6 for an addressing fault on interface 0 and 1. The ECC events are 8 for uncorrectable upper, 9 for correctable upper, 10 for uncorrectable lower and 11 for correctable lower.
- R3: A read of address 1 returns the status value from before the clock edge and clears the register at that edge. An event strobed in the same cycle as the read is still set after the clear.
- R4: Bit 7 (word position 24) is reserved. It always reads 0 in both the status and the mask register, whatever is strobed or written. Bits 12 to 31 (word positions 19:0) also read 0.
- R5: `irq` is high exactly when some status bit and the matching mask bit are both set.
- R6: A write to address 0 loads the mask with the defined bits of the write data. Writes to address 1 are ignored.
- R7: An enabled ECC event that arrives while no ECC status bit (8 to 11) is set captures the error address. The packing is burst count in word bits 31:30, rank in 29:27, column in 26:16, bank in 15:14 and row in 13:0.
- R8: While any ECC status bit is set, later ECC events leave the address and syndrome registers unchanged. An ECC event in the same cycle as a status read does capture.
- R9: The syndrome register takes the upper-half syndrome in word bits 15:8 and the lower-half syndrome in bits 7:0, at the same moment as the address capture. Bits 31:16 read 0. An upper byte of zero therefore marks a lower-half error.
- R10: Word bit 31 of address 4 is the global ECC enable. When it is 0, ECC strobes (events 8 to 11) neither set status nor capture. The processor-interface events are still recorded.
- R11: Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Register read strobe; data is on `bus_rdata` in the same cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_strobe | input | 12 | One-cycle event strobes, index n maps to register bit n |
| err_burst | input | 2 | Burst count of the failing access |
| err_rank | input | 3 | Rank of the failing access |
| err_col | input | 11 | Column address of the failing access |
| err_bank | input | 2 | Bank address of the failing access |
| err_row | input | 14 | Row address of the failing access |
| syn_hi | input | 8 | ECC syndrome of the upper half |
| syn_lo | input | 8 | ECC syndrome of the lower half |
| irq | output | 1 | Masked exception interrupt |

## Verification
The bench builds the block with its default field widths: 2, 3, 11, 2 and 14 bits of coordinates and two 8-bit syndromes. These fill the address word exactly, so the no-padding packing variant is elaborated. Every field boundary of the address word, as well as the top and bottom bits, can then be reached with chosen coordinate values. The directed checks cover the following cases:
- a read and an event in the same cycle;
- ECC events arriving while capture is held;
- ECC disabled;
- unmapped reads.

A random phase then mixes reads, mask and enable writes and sparse events. In that phase a behavioural model compares the read data and `irq` on every cycle.

// File: rtl/memerr_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the memory error capture block.
// Assumes the 32-bit register convention where bit 0 is the MSB.
package memerr_pkg;

    localparam int REG_W  = 32;
    localparam int EVT_N  = 12;
    localparam int RA_W   = 3;
    localparam int RSVD_N = 7;

    // Defined event bits, indexed by register bit number.
    localparam logic [EVT_N-1:0] EVT_DEF = 12'hF7F;
    // ECC event bits (8..11).
    localparam logic [EVT_N-1:0] EVT_ECC = 12'hF00;

    typedef enum logic [RA_W-1:0] {
        RA_MASK  = 3'd0,
        RA_STAT  = 3'd1,
        RA_EADDR = 3'd2,
        RA_SYN   = 3'd3,
        RA_CHK   = 3'd4
    } reg_sel_e;

    // Place event vector bit n at word position REG_W-1-n.
    function automatic logic [REG_W-1:0] evt_to_word(input logic [EVT_N-1:0] v);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < EVT_N; i++) begin
            w[REG_W-1-i] = v[i];
        end
        return w;
    endfunction

    // Extract event vector bit n from word position REG_W-1-n.
    function automatic logic [EVT_N-1:0] word_to_evt(input logic [REG_W-1:0] w);
        logic [EVT_N-1:0] v;
        for (int i = 0; i < EVT_N; i++) begin
            v[i] = w[REG_W-1-i];
        end
        return v;
    endfunction

endpackage

// File: rtl/memerr_status.sv
`timescale 1ns/1ps
// Sticky exception status and interrupt mask.
// The status register sets bits on gated event strobes and clears on a
// status read. An event in the clearing cycle still lands.
// Assumes evt_in has already been gated by the ECC enable.
module memerr_status #(
    parameter int                EVT_W    = memerr_pkg::EVT_N,
    parameter logic [EVT_W-1:0]  DEF_MASK = memerr_pkg::EVT_DEF,
    parameter logic [EVT_W-1:0]  ECC_MASK = memerr_pkg::EVT_ECC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             stat_clr,
    input  logic             mask_we,
    input  logic [EVT_W-1:0] mask_wdata,
    output logic [EVT_W-1:0] stat_q,
    output logic [EVT_W-1:0] mask_q,
    output logic             ecc_pending,
    output logic             irq
);

    logic [EVT_W-1:0] stat_base;

    // Base value for the next status: zero when being read, else held.
    always_comb begin
        stat_base = stat_clr ? '0 : stat_q;
    end

    // Sticky status register, OR-ing in defined events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_base | (evt_in & DEF_MASK);
        end
    end

    // Mask register, reset to all defined bits enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= DEF_MASK;
        end else if (mask_we) begin
            mask_q <= mask_wdata & DEF_MASK;
        end
    end

    // Pending ECC status and masked interrupt.
    always_comb begin
        ecc_pending = |(stat_q & ECC_MASK);
        irq         = |(stat_q & mask_q);
    end

endmodule

// File: rtl/memerr_capture.sv
`timescale 1ns/1ps
// Failing-access record: packed DRAM coordinates and both syndromes.
// Loads on the take strobe only. The caller decides first-error policy.
// Assumes the coordinate widths sum to no more than REG_W.
module memerr_capture #(
    parameter int REG_W   = memerr_pkg::REG_W,
    parameter int BURST_W = 2,
    parameter int RANK_W  = 3,
    parameter int COL_W   = 11,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 14,
    parameter int SYN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [BURST_W-1:0] err_burst,
    input  logic [RANK_W-1:0]  err_rank,
    input  logic [COL_W-1:0]   err_col,
    input  logic [BANK_W-1:0]  err_bank,
    input  logic [ROW_W-1:0]   err_row,
    input  logic [SYN_W-1:0]   syn_hi,
    input  logic [SYN_W-1:0]   syn_lo,
    output logic [REG_W-1:0]   addr_word,
    output logic [REG_W-1:0]   syn_word
);

    localparam int PACK_W = BURST_W + RANK_W + COL_W + BANK_W + ROW_W;
    localparam int PAD_W  = REG_W - PACK_W;
    localparam int SYNP_W = 2 * SYN_W;

    logic [PACK_W-1:0] addr_q;
    logic [SYNP_W-1:0] syn_q;

    // Record coordinates and syndromes on a qualified ECC event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            syn_q  <= '0;
        end else if (take) begin
            addr_q <= {err_burst, err_rank, err_col, err_bank, err_row};
            syn_q  <= {syn_hi, syn_lo};
        end
    end

    // Align the packed record to the MSB end of the word.
    generate
        if (PAD_W == 0) begin : g_full
            assign addr_word = addr_q;
        end else begin : g_pad
            assign addr_word = {addr_q, {PAD_W{1'b0}}};
        end
    endgenerate

    // Syndromes sit in the low bits, upper half above lower half.
    assign syn_word = REG_W'(syn_q);

endmodule

// File: rtl/memerr_regif.sv
`timescale 1ns/1ps
// Register port decode: read mux, write strobes and the ECC enable bit.
// Reads are combinational. Side effects take place at the clock edge.
module memerr_regif #(
    parameter int REG_W = memerr_pkg::REG_W,
    parameter int RA_W  = memerr_pkg::RA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [RA_W-1:0]  bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [REG_W-1:0] mask_word,
    input  logic [REG_W-1:0] stat_word,
    input  logic [REG_W-1:0] addr_word,
    input  logic [REG_W-1:0] syn_word,
    output logic [REG_W-1:0] bus_rdata,
    output logic             stat_clr,
    output logic             mask_we,
    output logic             ecc_en
);
    import memerr_pkg::*;

    reg_sel_e sel;
    logic     chk_we;

    // Decode the selected register and the strobes.
    always_comb begin
        sel      = reg_sel_e'(bus_addr);
        stat_clr = bus_rd && (sel == RA_STAT);
        mask_we  = bus_wr && (sel == RA_MASK);
        chk_we   = bus_wr && (sel == RA_CHK);
    end

    // Global ECC enable, reset to on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_en <= 1'b1;
        end else if (chk_we) begin
            ecc_en <= bus_wdata[REG_W-1];
        end
    end

    // Read data multiplexer, zero for unmapped addresses.
    always_comb begin
        case (sel)
            RA_MASK:  bus_rdata = mask_word;
            RA_STAT:  bus_rdata = stat_word;
            RA_EADDR: bus_rdata = addr_word;
            RA_SYN:   bus_rdata = syn_word;
            RA_CHK:   bus_rdata = {ecc_en, {(REG_W-1){1'b0}}};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/memerr_unit.sv
`timescale 1ns/1ps
// Memory error capture and exception register, top level.
// Gates ECC events by the global enable and arms the first-error capture.
// Status, mask and the address record live in the submodules.
// Assumes event strobes are one cycle wide and synchronous to clk.
module memerr_unit #(
    parameter int BURST_W = 2,
    parameter int RANK_W  = 3,
    parameter int COL_W   = 11,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 14,
    parameter int SYN_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [memerr_pkg::RA_W-1:0] bus_addr,
    input  logic [memerr_pkg::REG_W-1:0] bus_wdata,
    output logic [memerr_pkg::REG_W-1:0] bus_rdata,
    input  logic [memerr_pkg::EVT_N-1:0] evt_strobe,
    input  logic [BURST_W-1:0]          err_burst,
    input  logic [RANK_W-1:0]           err_rank,
    input  logic [COL_W-1:0]            err_col,
    input  logic [BANK_W-1:0]           err_bank,
    input  logic [ROW_W-1:0]            err_row,
    input  logic [SYN_W-1:0]            syn_hi,
    input  logic [SYN_W-1:0]            syn_lo,
    output logic                        irq
);
    import memerr_pkg::*;

    logic [EVT_N-1:0] evt_gated;
    logic [EVT_N-1:0] stat_vec;
    logic [EVT_N-1:0] mask_vec;
    logic [REG_W-1:0] stat_word;
    logic [REG_W-1:0] mask_word;
    logic [REG_W-1:0] addr_word;
    logic [REG_W-1:0] syn_word;
    logic             stat_clr;
    logic             mask_we;
    logic             ecc_en;
    logic             ecc_pending;
    logic             ecc_hit;
    logic             take;

    // Drop ECC events while collection is disabled.
    always_comb begin
        evt_gated = ecc_en ? evt_strobe : (evt_strobe & ~EVT_ECC);
        ecc_hit   = |(evt_gated & EVT_ECC);
        take      = ecc_hit && (!ecc_pending || stat_clr);
    end

    // Present event vectors in MSB-first register layout.
    always_comb begin
        stat_word = evt_to_word(stat_vec);
        mask_word = evt_to_word(mask_vec);
    end

    memerr_status #(
        .EVT_W    (EVT_N),
        .DEF_MASK (EVT_DEF),
        .ECC_MASK (EVT_ECC)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_in      (evt_gated),
        .stat_clr    (stat_clr),
        .mask_we     (mask_we),
        .mask_wdata  (word_to_evt(bus_wdata)),
        .stat_q      (stat_vec),
        .mask_q      (mask_vec),
        .ecc_pending (ecc_pending),
        .irq         (irq)
    );

    memerr_capture #(
        .REG_W   (REG_W),
        .BURST_W (BURST_W),
        .RANK_W  (RANK_W),
        .COL_W   (COL_W),
        .BANK_W  (BANK_W),
        .ROW_W   (ROW_W),
        .SYN_W   (SYN_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .err_burst (err_burst),
        .err_rank  (err_rank),
        .err_col   (err_col),
        .err_bank  (err_bank),
        .err_row   (err_row),
        .syn_hi    (syn_hi),
        .syn_lo    (syn_lo),
        .addr_word (addr_word),
        .syn_word  (syn_word)
    );

    memerr_regif #(
        .REG_W (REG_W),
        .RA_W  (RA_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mask_word (mask_word),
        .stat_word (stat_word),
        .addr_word (addr_word),
        .syn_word  (syn_word),
        .bus_rdata (bus_rdata),
        .stat_clr  (stat_clr),
        .mask_we   (mask_we),
        .ecc_en    (ecc_en)
    );

endmodule

// File: rtl/memerr_unit_chk.sv
`timescale 1ns/1ps
// Assertion checker for memerr_unit, attached by bind.
module memerr_unit_chk (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_rd,
    input logic                         bus_wr,
    input logic [memerr_pkg::RA_W-1:0]  bus_addr,
    input logic [memerr_pkg::REG_W-1:0] bus_rdata,
    input logic [memerr_pkg::EVT_N-1:0] evt_strobe,
    input logic                         irq,
    input logic [memerr_pkg::REG_W-1:0] stat_word,
    input logic [memerr_pkg::REG_W-1:0] addr_word
);
    import memerr_pkg::*;

    localparam logic [REG_W-1:0] ECC_WORD = evt_to_word(EVT_ECC);

    logic stat_read;
    assign stat_read = bus_rd && (bus_addr == RA_STAT);

    // R2: without a status read, no status bit falls.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_read |=> ((stat_word & $past(stat_word)) == $past(stat_word)));

    // R3: an event in the clearing cycle survives the clear.
    a_r3_survive: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && evt_strobe[3]) |=> stat_word[REG_W-1-3]);

    // R4: the reserved bit never reads as one from mask or status.
    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RA_MASK || bus_addr == RA_STAT) |-> !bus_rdata[REG_W-1-RSVD_N]);

    // R5: the interrupt rises only after an event or a mask write.
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|evt_strobe) || bus_wr));

    // R8: the captured address holds while ECC status is pending.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (((stat_word & ECC_WORD) != '0) && !stat_read) |=> $stable(addr_word));

    // R11: unmapped addresses read as zero.
    a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > RA_CHK) |-> (bus_rdata == '0));

endmodule

bind memerr_unit memerr_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .evt_strobe (evt_strobe),
    .irq        (irq),
    .stat_word  (stat_word),
    .addr_word  (addr_word)
);

// File: tb/memerr_unit_bench.sv
`timescale 1ns/100ps
module memerr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] evt = '0;
    logic [1:0]  e_burst = '0;
    logic [2:0]  e_rank = '0;
    logic [10:0] e_col = '0;
    logic [1:0]  e_bank = '0;
    logic [13:0] e_row = '0;
    logic [7:0]  s_hi = '0;
    logic [7:0]  s_lo = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_en = 0;
    logic [31:0] last_rd;
    logic        last_irq;

    // Reference model state, indexed by register bit number.
    logic [11:0] m_mask = 12'hF7F;
    logic [11:0] m_stat = '0;
    logic        m_en = 1'b1;
    logic [31:0] m_addr = '0;
    logic [31:0] m_syn = '0;

    always #2 clk = ~clk;

    memerr_unit u_memerr_unit (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_strobe(evt), .err_burst(e_burst), .err_rank(e_rank),
        .err_col(e_col), .err_bank(e_bank), .err_row(e_row),
        .syn_hi(s_hi), .syn_lo(s_lo), .irq(irq)
    );

    function automatic logic [31:0] to_w(input logic [11:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < 12; i++) if (v[i]) w = w | (32'h8000_0000 >> i);
        return w;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return to_w(m_mask);
            3'd1: return to_w(m_stat);
            3'd2: return m_addr;
            3'd3: return m_syn;
            3'd4: return m_en ? 32'h8000_0000 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Behavioural model update at each edge.
    always @(posedge clk) begin
        logic [11:0] eff;
        logic clr;
        if (!rst_n) begin
            m_mask = 12'hF7F; m_stat = '0; m_en = 1'b1; m_addr = '0; m_syn = '0;
        end else begin
            eff = evt & 12'hF7F;
            if (!m_en) eff = eff & 12'h0FF;
            clr = bus_rd && bus_addr == 3'd1;
            if ((eff & 12'hF00) != 0 && ((m_stat & 12'hF00) == 0 || clr)) begin
                m_addr = {e_burst, e_rank, e_col, e_bank, e_row};
                m_syn  = {16'h0, s_hi, s_lo};
            end
            m_stat = (clr ? 12'h0 : m_stat) | eff;
            if (bus_wr && bus_addr == 3'd0)
                for (int i = 0; i < 12; i++) m_mask[i] = bus_wdata[31-i] && (i != 7);
            if (bus_wr && bus_addr == 3'd4) m_en = bus_wdata[31];
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R5 irq", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
            chk("R11 rdata", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic cycle(input logic rd, input logic wr, input logic [2:0] a,
                         input logic [31:0] wd, input logic [11:0] ev);
        #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; evt = ev;
        #0.5;
        last_rd = bus_rdata;
        last_irq = irq;
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [2:0] a);
        cycle(1'b1, 1'b0, a, 32'h0, 12'h0);
    endtask

    task automatic set_coord(input logic [1:0] b, input logic [2:0] r, input logic [10:0] c,
                             input logic [1:0] k, input logic [13:0] w,
                             input logic [7:0] h, input logic [7:0] l);
        e_burst = b; e_rank = r; e_col = c; e_bank = k; e_row = w; s_hi = h; s_lo = l;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp1, exp2, exp3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        rd_reg(3'd0); chk("R1 mask reset", last_rd, 32'hFEF0_0000);
        rd_reg(3'd1); chk("R1 status reset", last_rd, 32'h0);
        rd_reg(3'd4); chk("R1 check-control reset", last_rd, 32'h8000_0000);
        rd_reg(3'd2); chk("R1 address reset", last_rd, 32'h0);
        rd_reg(3'd3); chk("R1 syndrome reset", last_rd, 32'h0);
        chk("R1 irq reset", {31'h0, last_irq}, 32'h0);

        // R2 event sets sticky bit; R5 interrupt
        cycle(0, 0, 3'd0, 0, 12'h010);
        cycle(0, 0, 3'd0, 0, 12'h000);
        chk("R5 irq after data error", {31'h0, last_irq}, 32'h1);
        cycle(0, 0, 3'd0, 0, 12'h000);
        rd_reg(3'd1); chk("R2 data error bit", last_rd, 32'h0800_0000);
        rd_reg(3'd1); chk("R3 cleared by read", last_rd, 32'h0);

        // R3 event in the clearing cycle survives
        cycle(0, 0, 3'd0, 0, 12'h010);
        cycle(1, 0, 3'd1, 0, 12'h001);
        chk("R3 read before clear", last_rd, 32'h0800_0000);
        rd_reg(3'd1); chk("R3 same-cycle event kept", last_rd, 32'h8000_0000);

        // R4 reserved bit
        cycle(0, 0, 3'd0, 0, 12'h080);
        rd_reg(3'd1); chk("R4 reserved status", last_rd, 32'h0);
        cycle(0, 1, 3'd0, 32'hFFFF_FFFF, 12'h0);
        rd_reg(3'd0); chk("R4 reserved mask", last_rd, 32'hFEF0_0000);

        // R6 mask write and ignored status write
        cycle(0, 1, 3'd0, 32'h0, 12'h0);
        cycle(0, 0, 3'd0, 0, 12'h020);
        cycle(0, 0, 3'd0, 0, 12'h000);
        chk("R6 masked irq low", {31'h0, last_irq}, 32'h0);
        rd_reg(3'd1); chk("R6 masked event still recorded", last_rd, 32'h0400_0000);
        cycle(0, 1, 3'd1, 32'hFFFF_FFFF, 12'h0);
        rd_reg(3'd1); chk("R6 status write ignored", last_rd, 32'h0);
        cycle(0, 1, 3'd0, 32'hFEF0_0000, 12'h0);

        // R7 capture on first ECC event
        set_coord(2'd2, 3'd5, 11'h5A3, 2'd1, 14'h2C7B, 8'h00, 8'h3C);
        exp1 = {2'd2, 3'd5, 11'h5A3, 2'd1, 14'h2C7B};
        cycle(0, 0, 3'd0, 0, 12'h800);
        rd_reg(3'd2); chk("R7 packed address", last_rd, exp1);
        rd_reg(3'd3); chk("R9 lower-half syndrome", last_rd, 32'h0000_003C);

        // R8 no overwrite while pending
        set_coord(2'd1, 3'd3, 11'h0F0, 2'd2, 14'h1234, 8'hA5, 8'h00);
        exp2 = {2'd1, 3'd3, 11'h0F0, 2'd2, 14'h1234};
        cycle(0, 0, 3'd0, 0, 12'h100);
        rd_reg(3'd2); chk("R8 address held", last_rd, exp1);
        rd_reg(3'd1); chk("R2 two ECC bits", last_rd, 32'h0090_0000);
        cycle(0, 0, 3'd0, 0, 12'h100);
        rd_reg(3'd2); chk("R8 recapture after clear", last_rd, exp2);
        rd_reg(3'd3); chk("R9 upper-half syndrome", last_rd, 32'h0000_A500);

        // R8 capture in the same cycle as the clearing read
        set_coord(2'd3, 3'd0, 11'h7FF, 2'd3, 14'h0001, 8'h11, 8'h22);
        exp3 = {2'd3, 3'd0, 11'h7FF, 2'd3, 14'h0001};
        cycle(1, 0, 3'd1, 0, 12'h400);
        rd_reg(3'd2); chk("R8 capture with clearing read", last_rd, exp3);
        rd_reg(3'd1); chk("R8 status after same-cycle event", last_rd, 32'h0020_0000);

        // R10 ECC disable
        cycle(0, 1, 3'd4, 32'h0, 12'h0);
        rd_reg(3'd4); chk("R10 enable cleared", last_rd, 32'h0);
        set_coord(2'd0, 3'd7, 11'h001, 2'd0, 14'h3FFF, 8'hFF, 8'hFF);
        cycle(0, 0, 3'd0, 0, 12'h200);
        rd_reg(3'd1); chk("R10 ECC event dropped", last_rd, 32'h0);
        rd_reg(3'd2); chk("R10 no capture", last_rd, exp3);
        cycle(0, 0, 3'd0, 0, 12'h002);
        rd_reg(3'd1); chk("R10 interface event kept", last_rd, 32'h4000_0000);
        cycle(0, 1, 3'd4, 32'h8000_0000, 12'h0);

        // R11 unmapped reads
        rd_reg(3'd5); chk("R11 address 5", last_rd, 32'h0);
        rd_reg(3'd7); chk("R11 address 7", last_rd, 32'h0);

        // Random mix, checked against the model every cycle
        for (int n = 0; n < 600; n++) begin
            set_coord($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
            cycle(($urandom % 4) == 0, ($urandom % 10) == 0, $urandom,
                  (($urandom % 3) == 0) ? 32'h0 : $urandom,
                  $urandom & $urandom & $urandom);
        end
        cycle(0, 0, 3'd0, 0, 12'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule